// File: doc/BRIEF.md
# Associative Inverted Page Translator

The block maps a virtual address onto a physical one. The virtual address arrives as a virtual page number and a word offset. The table inside is inverted: it has one slot for each physical page frame, and each slot records which virtual page that frame currently holds, together with a valid bit. On a lookup, every slot is compared with the requested page number at once. The number of the matching frame becomes the upper part of the physical address, and the word offset passes through unchanged as the lower part.

A write port loads or clears the slot of a chosen frame. It acts only while the supervisor-mode input is high, so a program running in user mode cannot change the mapping. Each lookup is answered exactly one clock later with a registered response and a valid strobe. A lookup that matches no valid slot reports a page fault and returns a physical address of zero. If several slots hold the same page, the lowest-numbered frame wins and an error flag is raised.

The response is held in a small state register with four states:
- `RSP_IDLE`: no answer this cycle.
- `RSP_HIT`: exactly one match.
- `RSP_MULTI`: several matches.
- `RSP_FAULT`: no match.

Every cycle the register moves, from whatever state it is in, to the state chosen by the current request:
- no request goes to `RSP_IDLE`;
- a request with no valid match goes to `RSP_FAULT`;
- a request with one match goes to `RSP_HIT`;
- a request with more than one match goes to `RSP_MULTI`.

Reset places the register in `RSP_IDLE`. The page size is 2^`OFS_W` words, and `OFS_W` is intended to be set between 9 and 11, which gives pages of 512 to 2048 words.

Top module: `ipt_xlate`

## Requirements
- R1: After reset every slot is invalid and `rsp_valid`, `rsp_fault`, `rsp_multi` and `rsp_paddr` are all 0. Any lookup made before a slot is loaded, including one for page 0, faults.
- R2: `rsp_valid` is high in the cycle after a cycle in which `req_valid` was high, and low in the cycle after a cycle in which `req_valid` was low. Back-to-back requests each get their own response.
- R3: On a lookup that hits, `rsp_paddr` equals (frame index << `OFS_W`) | `req_ofs`. The frame index fills bits [`PA_W`-1:`OFS_W`] and the offset fills bits [`OFS_W`-1:0].
- R4: On a lookup that matches no valid slot, `rsp_fault` is 1, `rsp_paddr` is 0 and `rsp_multi` is 0.
- R5: A supervisor write with `wr_inval`=1 clears the valid bit of frame `wr_frame`. That frame no longer matches any page until it is written again.
- R6: When two or more valid slots hold the requested page, the response uses the lowest matching frame index, `rsp_multi` is 1 and `rsp_fault` is 0.
- R7: Writes and invalidates with `sup_mode`=0 leave the table unchanged, so later lookups return the same results as before.
- R8: A lookup in the same cycle as a write sees the table as it was before that write. The write takes effect for lookups from the next cycle on.
- R9: In any cycle where `rsp_valid` is 0, `rsp_fault`, `rsp_multi` and `rsp_paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_mode | input | 1 | Supervisor mode; table writes are accepted only when this is 1 |
| wr_en | input | 1 | Table write strobe |
| wr_inval | input | 1 | 1: clear the slot; 0: load `wr_vpn` into the slot and mark it valid |
| wr_frame | input | FIDX_W | Frame whose slot is written |
| wr_vpn | input | VPN_W | Virtual page number to load |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_ofs | input | OFS_W | Word offset within the page |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | PA_W | Physical address, or 0 on a fault |
| rsp_fault | output | 1 | No valid slot matched |
| rsp_multi | output | 1 | More than one valid slot matched |

## Verification
Assertions check on every cycle:
- the one-cycle request-to-response timing;
- the quiet outputs when no answer is given;
- the zero address on a fault;
- the offset carried into the low address bits;
- that a lookup flagged as multiple matches never also reports a fault;
- that the table does not move while supervisor mode is low;
- that an invalidate clears its slot.

Some behaviour only the bench's scenarios can show, because it depends on what was loaded earlier:
- which frame a page maps to;
- that the lowest of several matching frames wins;
- that a lookup in the same cycle as a write sees the old table;
- that a rejected user-mode write really has no effect on later translations.

The bench covers these by running a table model and comparing against it on every clock.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    // Registered response state of the translator
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_HIT   = 2'd1,
        RSP_MULTI = 2'd2,
        RSP_FAULT = 2'd3
    } rsp_state_t;
endpackage

// File: rtl/ipt_entry_bank.sv
module ipt_entry_bank #(
    parameter int FRAMES = 16,
    parameter int VPN_W  = 20,
    localparam int FIDX_W = $clog2(FRAMES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sup_mode,
    input  logic                           wr_en,
    input  logic                           wr_inval,
    input  logic [FIDX_W-1:0]              wr_frame,
    input  logic [VPN_W-1:0]               wr_vpn,
    output logic [FRAMES-1:0]              ent_valid,
    output logic [FRAMES-1:0][VPN_W-1:0]   ent_vpn
);
    logic wr_ok;
    assign wr_ok = wr_en && sup_mode;

    for (genvar i = 0; i < FRAMES; i++) begin : g_slot
        logic sel;
        assign sel = wr_ok && (wr_frame == FIDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
                ent_vpn[i]   <= '0;
            end else if (sel) begin
                ent_valid[i] <= !wr_inval;
                if (!wr_inval) begin
                    ent_vpn[i] <= wr_vpn;
                end
            end
        end
    end

    // R7: user-mode writes leave the table untouched
    p_user_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_mode |=> ($stable(ent_valid) && $stable(ent_vpn)));

    // R5: a supervisor invalidate clears its slot
    p_inval_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_mode && wr_en && wr_inval && (int'(wr_frame) < FRAMES))
        |=> !ent_valid[$past(wr_frame)]);
endmodule

// File: rtl/ipt_match.sv
module ipt_match #(
    parameter int FRAMES = 16,
    parameter int VPN_W  = 20
) (
    input  logic [FRAMES-1:0]             ent_valid,
    input  logic [FRAMES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [VPN_W-1:0]              req_vpn,
    output logic [FRAMES-1:0]             hit
);
    // One comparator per frame, all evaluated in parallel
    for (genvar i = 0; i < FRAMES; i++) begin : g_cmp
        assign hit[i] = ent_valid[i] && (ent_vpn[i] == req_vpn);
    end
endmodule

// File: rtl/ipt_prio.sv
module ipt_prio #(
    parameter int FRAMES = 16,
    localparam int FIDX_W = $clog2(FRAMES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FRAMES-1:0]   hit,
    output logic                any_hit,
    output logic                multi,
    output logic [FIDX_W-1:0]   idx
);
    logic [FRAMES-1:0] hit_m1;

    assign any_hit = |hit;
    assign hit_m1  = hit - {{(FRAMES-1){1'b0}}, 1'b1};
    assign multi   = |(hit & hit_m1);

    // Lowest set bit wins: scan downward so the last assignment is the lowest
    always_comb begin
        idx = '0;
        for (int i = FRAMES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx = FIDX_W'(i);
            end
        end
    end

    // R6: the selected frame is one that matched
    p_grant_is_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit[idx]);

    // R6: the multiple-match flag means at least two comparators fired
    p_multi_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        multi |-> ($countones(hit) > 1));
endmodule

// File: rtl/ipt_xlate.sv
module ipt_xlate
    import ipt_pkg::*;
#(
    parameter int FRAMES = 16,
    parameter int VPN_W  = 20,
    parameter int OFS_W  = 10,
    localparam int FIDX_W = $clog2(FRAMES),
    localparam int PA_W   = FIDX_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sup_mode,
    input  logic               wr_en,
    input  logic               wr_inval,
    input  logic [FIDX_W-1:0]  wr_frame,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic               req_valid,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [OFS_W-1:0]   req_ofs,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_fault,
    output logic               rsp_multi
);
    logic [FRAMES-1:0]             ent_valid;
    logic [FRAMES-1:0][VPN_W-1:0]  ent_vpn;
    logic [FRAMES-1:0]             hit;
    logic                          any_hit;
    logic                          multi;
    logic [FIDX_W-1:0]             idx;

    rsp_state_t          state_q, state_d;
    logic [PA_W-1:0]     paddr_q, paddr_d;

    ipt_entry_bank #(.FRAMES(FRAMES), .VPN_W(VPN_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sup_mode  (sup_mode),
        .wr_en     (wr_en),
        .wr_inval  (wr_inval),
        .wr_frame  (wr_frame),
        .wr_vpn    (wr_vpn),
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn)
    );

    ipt_match #(.FRAMES(FRAMES), .VPN_W(VPN_W)) u_match (
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .req_vpn   (req_vpn),
        .hit       (hit)
    );

    ipt_prio #(.FRAMES(FRAMES)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .any_hit (any_hit),
        .multi   (multi),
        .idx     (idx)
    );

    // Next response state, chosen by the current request alone
    always_comb begin
        if (!req_valid) begin
            state_d = RSP_IDLE;
        end else if (!any_hit) begin
            state_d = RSP_FAULT;
        end else if (multi) begin
            state_d = RSP_MULTI;
        end else begin
            state_d = RSP_HIT;
        end
        paddr_d = (req_valid && any_hit) ? {idx, req_ofs} : '0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            paddr_q <= paddr_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_multi = 1'b0;
        unique case (state_q)
            RSP_IDLE:  ;
            RSP_HIT:   rsp_valid = 1'b1;
            RSP_MULTI: begin
                rsp_valid = 1'b1;
                rsp_multi = 1'b1;
            end
            RSP_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default:   ;
        endcase
        rsp_paddr = paddr_q;
    end

    // R2: a response follows each request one cycle later, and only then
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: a fault carries a zero address
    p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0) && !rsp_multi);

    // R3: the word offset lands unchanged in the low address bits
    p_offset_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFS_W-1:0] == $past(req_ofs)));

    // R6: a multiple match is still a successful translation
    p_multi_is_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> (rsp_valid && !rsp_fault));

    // R9: outputs are quiet when no response is given
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && !rsp_multi && (rsp_paddr == '0)));
endmodule

// File: tb/sim_ipt_xlate.sv
`timescale 1ns/1ps
module sim_ipt_xlate;
    localparam int FR = 8;
    localparam int VW = 10;
    localparam int OW = 9;
    localparam int FW = 3;
    localparam int PW = FW + OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sup_mode = 1'b0, wr_en = 1'b0, wr_inval = 1'b0;
    logic [FW-1:0] wr_frame = '0;
    logic [VW-1:0] wr_vpn = '0;
    logic          req_valid = 1'b0;
    logic [VW-1:0] req_vpn = '0;
    logic [OW-1:0] req_ofs = '0;
    logic          rsp_valid, rsp_fault, rsp_multi;
    logic [PW-1:0] rsp_paddr;

    always #2 clk = ~clk;

    ipt_xlate #(.FRAMES(FR), .VPN_W(VW), .OFS_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .wr_en(wr_en),
        .wr_inval(wr_inval), .wr_frame(wr_frame), .wr_vpn(wr_vpn),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_ofs(req_ofs),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_multi(rsp_multi)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural table model
    bit mv[FR];
    int mvpn[FR];

    task automatic check(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: predict from the model, update it, compare all outputs
    task automatic cyc(string tag);
        int e_v, e_pa, e_f, e_m, cnt, first;
        @(posedge clk);
        e_v = 0; e_pa = 0; e_f = 0; e_m = 0;
        if (req_valid) begin
            cnt = 0; first = -1;
            for (int f = 0; f < FR; f++) begin
                if (mv[f] && mvpn[f] == int'(req_vpn)) begin
                    cnt++;
                    if (first < 0) first = f;
                end
            end
            e_v = 1;
            if (cnt == 0) e_f = 1;
            else begin
                e_pa = (first << OW) | int'(req_ofs);
                e_m  = (cnt > 1) ? 1 : 0;
            end
        end
        if (wr_en && sup_mode) begin
            if (wr_inval) mv[wr_frame] = 1'b0;
            else begin
                mv[wr_frame]   = 1'b1;
                mvpn[wr_frame] = int'(wr_vpn);
            end
        end
        #1;
        check(tag, "rsp_valid", int'(rsp_valid), e_v);
        check(tag, "rsp_paddr", int'(rsp_paddr), e_pa);
        check(tag, "rsp_fault", int'(rsp_fault), e_f);
        check(tag, "rsp_multi", int'(rsp_multi), e_m);
        @(negedge clk);
        sup_mode = 1'b0; wr_en = 1'b0; wr_inval = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic wr(bit sup, int frame, int vpn, bit inval, string tag);
        sup_mode = sup; wr_en = 1'b1; wr_inval = inval;
        wr_frame = FW'(frame); wr_vpn = VW'(vpn);
        cyc(tag);
    endtask

    task automatic lk(int vpn, int ofs, string tag);
        req_valid = 1'b1; req_vpn = VW'(vpn); req_ofs = OW'(ofs);
        cyc(tag);
    endtask

    task automatic flush(string tag);
        cyc(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int f = 0; f < FR; f++) begin mv[f] = 1'b0; mvpn[f] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1", "reset rsp_valid", int'(rsp_valid), 0);
        check("R1", "reset rsp_paddr", int'(rsp_paddr), 0);
        rst_n = 1'b1;
        flush("R1");
        lk(0, 5, "R1");          // page 0 must fault on an empty table
        flush("R9");

        // Load some slots (R9 idle outputs checked on these cycles)
        wr(1, 3, 'h012, 0, "R9");
        wr(1, 5, 'h040, 0, "R9");
        wr(1, 0, 'h3FF, 0, "R9");

        // R3: hits with assorted offsets, back-to-back for R2
        lk('h012, 0,     "R3");
        lk('h040, 'h1FF, "R3");
        lk('h3FF, 'h0AA, "R2");
        flush("R2");
        lk('h012, 'h155, "R3");

        // R4: miss
        lk('h077, 'h033, "R4");

        // R7: user-mode write and invalidate have no effect
        wr(0, 6, 'h077, 0, "R7");
        wr(0, 3, 0,     1, "R7");
        lk('h077, 1, "R7");
        lk('h012, 2, "R7");

        // R5: supervisor invalidate removes frame 5
        wr(1, 5, 0, 1, "R5");
        lk('h040, 3, "R5");
        wr(1, 5, 'h041, 0, "R5");
        lk('h041, 4, "R5");

        // R6: duplicates, lowest frame wins
        wr(1, 7, 'h012, 0, "R6");
        lk('h012, 6, "R6");
        wr(1, 1, 'h012, 0, "R6");
        lk('h012, 7, "R6");
        wr(1, 1, 0, 1, "R6");
        wr(1, 3, 0, 1, "R6");
        lk('h012, 8, "R6");      // only frame 7 remains

        // R8: write and lookup in the same cycle see the old table
        sup_mode = 1'b1; wr_en = 1'b1; wr_inval = 1'b0;
        wr_frame = FW'(2); wr_vpn = VW'('h055);
        req_valid = 1'b1; req_vpn = VW'('h055); req_ofs = OW'('h010);
        cyc("R8");
        lk('h055, 'h011, "R8");
        sup_mode = 1'b1; wr_en = 1'b1; wr_inval = 1'b1; wr_frame = FW'(2);
        req_valid = 1'b1; req_vpn = VW'('h055); req_ofs = OW'('h012);
        cyc("R8");
        lk('h055, 'h013, "R8");
        flush("R9");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule